// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block collects up to 32 synchronous interrupt request lines and turns them into two requests toward a processor: a normal request and a fast request. Each line has its own configuration word. The word sets a 5-bit priority, chooses between edge and level sensing, and routes the line to one of the two request classes. Lines latch into a pending register. A mask register can block any line from taking part.

Each request class works as a one-shot. When the class is armed and an unmasked pending line of that class exists, the block raises the request output and latches the number of the winning line. It then disarms the class. The processor reads the latched number from the class's vector register. For an edge-sensed line, that read also acknowledges the line. The processor re-arms the class through the control register, and only then can the output fire again. Software can also inject a request on any line through a trigger register.

All access goes through a simple 32-bit word-wide register bus. A write takes effect on the clock edge while select and write-enable are high. Read data is returned combinationally while select is high and write-enable is low.

Top module: `prio_intc`

## Requirements
- R1: After reset, the state is as follows. Pending is 0. Every configuration word is 0, meaning edge-sensed, normal class, priority 0. Mask reads 0xFFFFFFFF. Both vector registers read 0. Both request outputs are low and both classes are armed.
- R2: The register offsets are: pending 0x00, mask 0x04, normal vector 0x10, fast vector 0x14, control 0x18, line n configuration 0x1C+4n, software trigger 0x9C. A configuration word holds the priority in bits [6:2], level sensing in bit 1 (1 = level, 0 = edge) and fast routing in bit 0 (1 = fast class). It reads back with all higher bits 0.
- R3: An edge-sensed line becomes pending only when its input goes from 0 in one cycle to 1 in the next. The bit stays set after the input falls. An input held high does not set the bit again once software has cleared it.
- R4: A level-sensed line is pending one cycle after its input is high. Its pending bit clears one cycle after the input goes low.
- R5: A write to the pending register clears each bit written as 0, except bits of level-sensed lines whose input is high. Bits written as 1 are left as they are; they are never set.
- R6: Assume a class is armed and an unmasked pending line of that class exists. On the next clock edge the class output goes high, the winning line number is latched into that class's vector, and the class is disarmed. An input that goes high therefore raises the output two edges later.
- R7: A raised output stays high, with its vector unchanged, until a control write with bit 0 (normal) or bit 1 (fast) set. That write drives the output low and re-arms the class. If a qualifying line is still pending, the output rises again on the following edge.
- R8: Among the candidate lines of a class, the line with the smallest priority value wins. When priorities tie, the highest-numbered line wins.
- R9: A read of a vector register returns the latched line number. If that line is edge-sensed, the read clears its pending bit. A level-sensed pending bit is not affected.
- R10: A line whose mask bit is 1 never raises an output. Clearing the mask bit of a pending line lets it raise the output. The mask reads back as written.
- R11: A write to the software trigger register acts as a one-cycle input pulse on the lowest-numbered line whose bit is set. Other set bits are ignored. On an edge-sensed line with a low input, this makes the line pending. The register reads as 0.
- R12: The control register reads as 0. Writes to the vector registers have no effect. Offsets not listed in R2 read as 0, and writes to them change nothing.
- R13: A line routed to the fast class can raise only the fast output, and a normal-class line can raise only the normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected, 0 otherwise |
| irq_lines | input | NUM_LINES | Synchronous active-high interrupt requests |
| irq_req | output | 1 | Normal-class request to the processor |
| fiq_req | output | 1 | Fast-class request to the processor |

## Verification
Some properties are checked on every cycle. A raised output always implies a disarmed class. An output stays high, with its vector frozen, until the matching control bit is written. Level-sensed pending bits never disagree with the previous cycle's input. The control and trigger registers always read 0.

Other behaviour only the bench scenarios can show. These are:
- which line wins arbitration under many priority and mask patterns;
- the two-edge latency from input to output;
- acknowledgement by a vector read;
- the pending-clear exception for level lines;
- the lowest-bit rule of the software trigger.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int PRIO_W   = 5;
    localparam int CFG_W    = PRIO_W + 2;
    localparam int CFG_BASE = 'h1C;

    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_VECN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_VECF   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_SWTRIG = 8'h9C;

    typedef enum logic { CLS_NORMAL = 1'b0, CLS_FAST = 1'b1 } req_class_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              to_fast;
    } line_cfg_t;

    function automatic line_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        line_cfg_t c;
        c.prio    = w[CFG_W-1:2];
        c.level   = w[1];
        c.to_fast = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] lowest_one(input logic [DATA_W-1:0] v);
        return v & (~v + DATA_W'(1));
    endfunction
endpackage

// File: rtl/pic_pending.sv
`timescale 1ns/1ps
module pic_pending #(
    parameter int NUM_LINES = 32,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic [NUM_LINES-1:0] sw_pulse,
    input  logic [NUM_LINES-1:0] level_mask,
    input  logic                 wr_pend,
    input  logic [NUM_LINES-1:0] wr_keep,
    input  logic                 ack_vld,
    input  logic [LINE_W-1:0]    ack_idx,
    output logic [NUM_LINES-1:0] pending
);
    logic [NUM_LINES-1:0] eff_in;
    logic [NUM_LINES-1:0] eff_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] pend_d;
    logic [NUM_LINES-1:0] rise;

    assign eff_in = lines_in | sw_pulse;
    assign rise   = eff_in & ~eff_q & ~level_mask;

    always_comb begin
        pend_d = pend_q;
        // software clear, level lines with an active input survive
        if (wr_pend) begin
            pend_d = pend_d & (wr_keep | (eff_in & level_mask));
        end
        // vector read acknowledges only edge lines
        if (ack_vld && !level_mask[ack_idx]) begin
            pend_d[ack_idx] = 1'b0;
        end
        // level lines follow their input
        pend_d = (pend_d & ~level_mask) | (eff_in & level_mask);
        // new edges win over any clear in the same cycle
        pend_d = pend_d | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_q  <= '0;
            pend_q <= '0;
        end else begin
            eff_q  <= eff_in;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             cand,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic                             hit,
    output logic [LINE_W-1:0]                win_idx
);
    logic [PRIO_W-1:0] best_p;

    // ascending scan with <= : ties resolve to the highest line number
    always_comb begin
        hit     = 1'b0;
        best_p  = '1;
        win_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!hit || prio[i] <= best_p)) begin
                hit     = 1'b1;
                best_p  = prio[i];
                win_idx = LINE_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_agreement.sv
`timescale 1ns/1ps
module pic_agreement #(
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rearm,
    input  logic              hit,
    input  logic [LINE_W-1:0] win_idx,
    output logic              req,
    output logic              armed,
    output logic [LINE_W-1:0] vec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            armed <= 1'b1;
            vec   <= '0;
        end else if (rearm) begin
            req   <= 1'b0;
            armed <= 1'b1;
        end else if (armed && hit) begin
            req   <= 1'b1;
            armed <= 1'b0;
            vec   <= win_idx;
        end
    end
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_req,
    output logic                 fiq_req
);
    localparam int LINE_W = $clog2(NUM_LINES);
    localparam int NCLS   = 2;

    logic wr_en, rd_en;
    logic ctrl_hit, swtrig_hit, pend_hit, mask_hit;
    logic ack_vld;
    logic [LINE_W-1:0] ack_idx;

    logic [NUM_LINES-1:0]             mask_q;
    logic [NUM_LINES-1:0]             pend_q;
    logic [NUM_LINES-1:0]             level_mask;
    logic [NUM_LINES-1:0]             route_fast;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_vec;
    logic [NUM_LINES-1:0]             sw_pulse;
    logic [DATA_W-1:0]                sw_onehot;

    logic [NCLS-1:0]             cls_req;
    logic [NCLS-1:0]             cls_armed;
    logic [NCLS-1:0][LINE_W-1:0] cls_vec;

    logic [DATA_W-1:0] rd_word;

    assign wr_en      = bus_sel && bus_we;
    assign rd_en      = bus_sel && !bus_we;
    assign pend_hit   = wr_en && (bus_addr == OFS_PEND);
    assign mask_hit   = wr_en && (bus_addr == OFS_MASK);
    assign ctrl_hit   = wr_en && (bus_addr == OFS_CTRL);
    assign swtrig_hit = wr_en && (bus_addr == OFS_SWTRIG);

    // software trigger: only the lowest set bit becomes a pulse
    assign sw_onehot = lowest_one(bus_wdata);
    assign sw_pulse  = swtrig_hit ? sw_onehot[NUM_LINES-1:0] : '0;

    // vector reads acknowledge the latched line
    always_comb begin
        ack_vld = 1'b0;
        ack_idx = cls_vec[CLS_NORMAL];
        if (rd_en && bus_addr == OFS_VECN) begin
            ack_vld = 1'b1;
            ack_idx = cls_vec[CLS_NORMAL];
        end else if (rd_en && bus_addr == OFS_VECF) begin
            ack_vld = 1'b1;
            ack_idx = cls_vec[CLS_FAST];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_hit) begin
            mask_q <= bus_wdata[NUM_LINES-1:0];
        end
    end

    // per-line configuration words
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_cfg
        localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(CFG_BASE + 4 * n);
        line_cfg_t cfg_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r <= '0;
            end else if (wr_en && bus_addr == CFG_OFS) begin
                cfg_r <= unpack_cfg(bus_wdata[CFG_W-1:0]);
            end
        end

        assign prio_vec[n]   = cfg_r.prio;
        assign level_mask[n] = cfg_r.level;
        assign route_fast[n] = cfg_r.to_fast;
    end

    pic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .lines_in   (irq_lines),
        .sw_pulse   (sw_pulse),
        .level_mask (level_mask),
        .wr_pend    (pend_hit),
        .wr_keep    (bus_wdata[NUM_LINES-1:0]),
        .ack_vld    (ack_vld),
        .ack_idx    (ack_idx),
        .pending    (pend_q)
    );

    // one arbiter and one agreement stage per request class
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [NUM_LINES-1:0] cand;
        logic                 hit;
        logic [LINE_W-1:0]    win;

        assign cand = pend_q & ~mask_q & ((c == 1) ? route_fast : ~route_fast);

        pic_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
            .cand    (cand),
            .prio    (prio_vec),
            .hit     (hit),
            .win_idx (win)
        );

        pic_agreement #(.LINE_W(LINE_W)) u_agr (
            .clk     (clk),
            .rst     (rst),
            .rearm   (ctrl_hit && bus_wdata[c]),
            .hit     (hit),
            .win_idx (win),
            .req     (cls_req[c]),
            .armed   (cls_armed[c]),
            .vec     (cls_vec[c])
        );
    end

    assign irq_req = cls_req[CLS_NORMAL];
    assign fiq_req = cls_req[CLS_FAST];

    // read mux
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFS_PEND: rd_word = DATA_W'(pend_q);
            OFS_MASK: rd_word = DATA_W'(mask_q);
            OFS_VECN: rd_word = DATA_W'(cls_vec[CLS_NORMAL]);
            OFS_VECF: rd_word = DATA_W'(cls_vec[CLS_FAST]);
            default:  rd_word = '0;
        endcase
        for (int n = 0; n < NUM_LINES; n++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + 4 * n)) begin
                rd_word = DATA_W'({prio_vec[n], level_mask[n], route_fast[n]});
            end
        end
    end

    assign bus_rdata = rd_en ? rd_word : '0;
endmodule

// File: rtl/prio_intc_checker.sv
`timescale 1ns/1ps
module prio_intc_checker
    import pic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 irq_req,
    input logic                 fiq_req,
    input logic [NUM_LINES-1:0] pending,
    input logic [NUM_LINES-1:0] level_mask,
    input logic [1:0]           armed,
    input logic [LINE_W-1:0]    vec_n,
    input logic [LINE_W-1:0]    vec_f
);
    logic ctrl_wr, swtrig_wr;
    assign ctrl_wr   = bus_sel && bus_we && bus_addr == OFS_CTRL;
    assign swtrig_wr = bus_sel && bus_we && bus_addr == OFS_SWTRIG;

    a_r6_normal_disarmed: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !armed[0]);
    a_r6_fast_disarmed: assert property (@(posedge clk) disable iff (rst)
        fiq_req |-> !armed[1]);

    a_r7_normal_held: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !(ctrl_wr && bus_wdata[0])) |=> irq_req);
    a_r7_fast_held: assert property (@(posedge clk) disable iff (rst)
        (fiq_req && !(ctrl_wr && bus_wdata[1])) |=> fiq_req);

    a_r7_normal_vec_stable: assert property (@(posedge clk) disable iff (rst)
        !$rose(irq_req) |-> $stable(vec_n));
    a_r7_fast_vec_stable: assert property (@(posedge clk) disable iff (rst)
        !$rose(fiq_req) |-> $stable(vec_f));

    a_r4_level_low_clear: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(swtrig_wr)) |->
        ((pending & $past(level_mask) & ~$past(irq_lines)) == '0));
    a_r4_level_high_set: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        ((~pending & $past(level_mask) & $past(irq_lines)) == '0));

    a_r12_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == OFS_CTRL) |-> bus_rdata == '0);
    a_r11_swtrig_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == OFS_SWTRIG) |-> bus_rdata == '0);
endmodule

bind prio_intc prio_intc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_lines  (irq_lines),
    .irq_req    (irq_req),
    .fiq_req    (fiq_req),
    .pending    (pend_q),
    .level_mask (level_mask),
    .armed      (cls_armed),
    .vec_n      (cls_vec[0]),
    .vec_f      (cls_vec[1])
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
    localparam int N = 32;
    localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_VECN = 8'h10,
                           A_VECF = 8'h14, A_CTRL = 8'h18, A_SWT = 8'h9C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_lines = '0;
    logic        irq_req, fiq_req;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    prio_intc #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .irq_req(irq_req), .fiq_req(fiq_req)
    );

    function automatic logic [7:0] cfg_ofs(input int n);
        return 8'(8'h1C + 4 * n);
    endfunction

    function automatic int prio_of(input int i, input int k);
        return (i * (2 * k + 3) + k) % 7;
    endfunction

    function automatic int exp_winner(input int k, input logic [31:0] msk);
        int best_p = 99;
        int best_i = 0;
        for (int i = 0; i < N; i++) begin
            if (!msk[i] && prio_of(i, k) <= best_p) begin
                best_p = prio_of(i, k);
                best_i = i;
            end
        end
        return best_i;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic set_lines(input logic [N-1:0] v);
        @(negedge clk);
        irq_lines = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] msk;
        idle(4);
        rst = 1'b0;

        // R1 reset state
        check("R1", "irq_req", 32'(irq_req), 0);
        check("R1", "fiq_req", 32'(fiq_req), 0);
        rd(A_PEND, d); check("R1", "pending", d, 0);
        rd(A_MASK, d); check("R1", "mask", d, 32'hFFFF_FFFF);
        rd(A_VECN, d); check("R1", "normal vector", d, 0);
        rd(A_VECF, d); check("R1", "fast vector", d, 0);
        for (int n = 0; n < N; n++) begin
            rd(cfg_ofs(n), d); check("R1", "config word", d, 0);
        end

        // R2 configuration word layout, junk above bit 6 dropped
        for (int n = 0; n < N; n++) begin
            wr(cfg_ofs(n), 32'hABCD_0000 | 32'((n * 37 + 11) & 8'h7F));
        end
        for (int n = 0; n < N; n++) begin
            rd(cfg_ofs(n), d); check("R2", "config readback", d, 32'((n * 37 + 11) & 8'h7F));
        end
        for (int n = 0; n < N; n++) wr(cfg_ofs(n), 0);

        // R3 edge lines, all masked
        for (int n = 0; n < N; n++) begin
            set_lines(N'(1) << n);
            rd(A_PEND, d); check("R3", "edge set", d, 32'(1) << n);
            set_lines('0);
            rd(A_PEND, d); check("R3", "edge kept after fall", d, 32'(1) << n);
            wr(A_PEND, 0);
            rd(A_PEND, d); check("R5", "clear edge", d, 0);
        end
        set_lines(N'(1) << 4);
        idle(1);
        wr(A_PEND, 0);
        idle(2);
        rd(A_PEND, d); check("R3", "held high no retrigger", d, 0);
        set_lines('0);

        // R4 / R5 level line 3 next to edge line 10
        wr(cfg_ofs(3), 32'h2);
        set_lines((N'(1) << 3) | (N'(1) << 10));
        rd(A_PEND, d); check("R4", "level and edge set", d, 32'h0000_0408);
        wr(A_PEND, 0);
        rd(A_PEND, d); check("R5", "level survives clear", d, 32'h0000_0008);
        set_lines('0);
        rd(A_PEND, d); check("R4", "level clears on low", d, 0);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, d); check("R5", "ones do not set", d, 0);
        wr(cfg_ofs(3), 0);

        // R8 / R10 arbitration sweep
        for (int k = 0; k < 8; k++) begin
            msk = k[0] ? 32'h0F0F_0F0F : 32'h0;
            wr(A_MASK, msk);
            for (int i = 0; i < N; i++) wr(cfg_ofs(i), 32'(prio_of(i, k) << 2));
            set_lines('1);
            idle(2);
            check("R8", "normal raised", 32'(irq_req), 1);
            check("R13", "fast quiet", 32'(fiq_req), 0);
            rd(A_VECN, d); check("R8", "winner", d, 32'(exp_winner(k, msk)));
            set_lines('0);
            wr(A_PEND, 0);
            wr(A_CTRL, 1);
            idle(1);
            check("R7", "normal dropped after rearm", 32'(irq_req), 0);
        end
        for (int i = 0; i < N; i++) wr(cfg_ofs(i), 0);

        // R6 / R7 latency, hold and re-raise
        wr(A_MASK, ~32'h0000_0060);
        set_lines(N'(1) << 5);
        @(negedge clk);
        check("R6", "no raise after one edge", 32'(irq_req), 0);
        @(negedge clk);
        check("R6", "raise after two edges", 32'(irq_req), 1);
        rd(A_VECN, d); check("R6", "vector latched", d, 5);
        set_lines(N'(1) << 6);
        idle(3);
        check("R7", "held high", 32'(irq_req), 1);
        rd(A_VECN, d); check("R7", "vector held", d, 5);
        wr(A_CTRL, 1);
        check("R7", "dropped by control", 32'(irq_req), 0);
        @(negedge clk);
        check("R7", "re-raised next edge", 32'(irq_req), 1);
        rd(A_VECN, d); check("R7", "new vector", d, 6);
        rd(A_PEND, d); check("R9", "edge acked by read", d, 0);
        set_lines('0);
        wr(A_CTRL, 1);

        // R10 mask blocks then releases
        wr(A_MASK, 32'hFFFF_FFFF);
        set_lines(N'(1) << 7);
        idle(4);
        check("R10", "masked quiet", 32'(irq_req), 0);
        rd(A_MASK, d); check("R10", "mask readback", d, 32'hFFFF_FFFF);
        wr(A_MASK, ~(32'(1) << 7));
        @(negedge clk);
        check("R10", "unmask raises", 32'(irq_req), 1);
        rd(A_VECN, d); check("R10", "vector", d, 7);
        set_lines('0);
        wr(A_CTRL, 1);

        // R13 / R9 fast routing, edge line
        wr(cfg_ofs(9), 32'h1);
        wr(A_MASK, ~(32'(1) << 9));
        set_lines(N'(1) << 9);
        idle(2);
        check("R13", "fast raised", 32'(fiq_req), 1);
        check("R13", "normal quiet", 32'(irq_req), 0);
        rd(A_VECF, d); check("R13", "fast vector", d, 9);
        rd(A_PEND, d); check("R9", "fast edge acked", d, 0);
        set_lines('0);
        wr(A_CTRL, 2);
        check("R7", "fast dropped", 32'(fiq_req), 0);

        // R9 level fast line not acked by read
        wr(cfg_ofs(12), 32'h3);
        wr(A_MASK, ~(32'(1) << 12));
        set_lines(N'(1) << 12);
        idle(2);
        rd(A_VECF, d); check("R9", "level fast vector", d, 12);
        rd(A_PEND, d); check("R9", "level not acked", d, 32'(1) << 12);
        set_lines('0);
        rd(A_PEND, d); check("R4", "level cleared", d, 0);
        wr(A_CTRL, 2);
        idle(1);
        check("R7", "fast stays low", 32'(fiq_req), 0);
        wr(cfg_ofs(9), 0);
        wr(cfg_ofs(12), 0);
        wr(A_MASK, 32'hFFFF_FFFF);

        // R11 software trigger
        wr(A_SWT, 32'h0000_00C0);
        rd(A_PEND, d); check("R11", "lowest bit only", d, 32'h0000_0040);
        rd(A_SWT, d); check("R11", "reads zero", d, 0);
        wr(A_PEND, 0);
        wr(A_SWT, 32'h8000_0000);
        rd(A_PEND, d); check("R11", "top line", d, 32'h8000_0000);
        wr(A_PEND, 0);

        // R12 read-only and undefined offsets
        rd(A_CTRL, d); check("R12", "control reads zero", d, 0);
        wr(A_VECN, 32'h1F);
        rd(A_VECN, d); check("R12", "vector write ignored", d, 7);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R12", "undefined reads zero", d, 0);
        rd(A_PEND, d); check("R12", "pending untouched", d, 0);
        rd(A_MASK, d); check("R12", "mask untouched", d, 32'hFFFF_FFFF);

        finish_run();
    end
endmodule